// File: doc/BRIEF.md
# Multi-Segment SPI Command Sequencer

This block drives an SPI message made of up to four segments. Each segment has its own frame format, its own lane mode (single, dual or quad), its own direction and its own 32-bit frame count. The sequencer sits between a table of command words and a separate bit shifter. On a start request it walks the table from entry 0 up to a programmable last index. For each entry it shows that entry's fields on its outputs and sends one frame-start pulse per frame. Before it sends the next pulse, it waits for the shifter to report that the frame is done.

Chip select is held across segment boundaries when the finished entry asks for it, and released otherwise. When the last entry completes, the block signals done, releases chip select and points back at entry 0. The per-entry delay enables choose between the shared delay settings and the minimum delay, and the result goes to the shifter. The block does no clocking or shifting of its own.

Top module: `spi_cmd_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `frame_start` and `cs_active` are low and `cmd_ptr` is 0.
- R2: A `start` pulse while idle runs entries 0 through `seq_last` in ascending order. A `seq_last` value above NUM_CMD-1 is treated as NUM_CMD-1. `cmd_ptr` shows the entry whose frames are being issued.
- R3: An entry with multiplier m issues exactly m `frame_start` pulses, each lasting one cycle. Only one frame is ever outstanding: the next pulse comes only after a `frame_done` pulse for the current frame.
- R4: An entry whose multiplier is zero issues no `frame_start`, and the sequence continues with the next entry.
- R5: `cs_active` is high whenever `frame_start` is high and stays high between frames of one segment. Between segments it stays high if every entry that finished in between has its keep bit (command bit 3) set. Otherwise it drops for at least one cycle.
- R6: When the last entry completes, `done` is high for exactly one cycle. In that cycle `cs_active` is low and `cmd_ptr` is 0.
- R7: While an entry's frames are issued, `act_cmd` equals that entry's 16-bit command word and `lane_mode` equals its bits [1:0] (00 single, 01 dual, 10 quad).
- R8: `multi_rd` is high when the active lane mode is not single and the direction bit (bit 2) is 1. `multi_wr` is high when the lane mode is not single and bit 2 is 0. In single mode both are low.
- R9: `lead_dly`, `lag_dly` and `gap_dly` equal `lead_set`, `lag_set` and `gap_set` when command bits 13, 14 and 15 are set, respectively, and 0 otherwise. A code c means c+1 SCK periods.
- R10: `start` has no effect while `busy` is high, and `frame_done` has no effect when no frame is outstanding. `busy` falls only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only while idle) |
| cmd_table | input | NUM_CMD*16 | Command words, entry i at bits [16i+15:16i] |
| mult_table | input | NUM_CMD*MULT_W | Frame counts, entry i at bits [MULT_W*i +: MULT_W] |
| seq_last | input | PTR_W | Index of the last entry to run |
| lead_set | input | DLY_W | Shared clock-to-data delay setting |
| lag_set | input | DLY_W | Shared chip-select release delay setting |
| gap_set | input | DLY_W | Shared next-access delay setting |
| frame_done | input | 1 | Shifter reports the outstanding frame finished |
| cmd_ptr | output | PTR_W | Entry currently executing |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| frame_start | output | 1 | One-cycle request for the shifter to run a frame |
| cs_active | output | 1 | Chip select asserted |
| act_cmd | output | 16 | Command word of the active entry |
| lane_mode | output | 2 | Lane mode of the active entry |
| multi_rd | output | 1 | Active entry is a multi-lane read |
| multi_wr | output | 1 | Active entry is a multi-lane write |
| lead_dly | output | DLY_W | Effective clock-to-data delay code |
| lag_dly | output | DLY_W | Effective chip-select release delay code |
| gap_dly | output | DLY_W | Effective next-access delay code |

## Verification
The hardest case to reach is a segment boundary where a zero-count entry sits between two active entries with different keep bits. Whether chip select must drop then depends on the keep bit of the skipped entry, not only on its neighbours. The stimulus reaches this with directed tables that put zero counts first, in the middle and last. Random tables mix zero and non-zero counts with random keep bits across every sequence length, including lengths beyond the table size. A bench model of the shifter answers each frame after a random delay, so the one-outstanding-frame rule is tested with varied handshake timing. Stray start and frame-done pulses are injected during runs and while idle.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

   localparam int CMD_W = 16;

   typedef enum logic [1:0] {
      LANE_X1  = 2'b00,
      LANE_X2  = 2'b01,
      LANE_X4  = 2'b10,
      LANE_RSV = 2'b11
   } lane_e;

   // Command word, most significant field first
   typedef struct packed {
      logic       nxt_en;   // [15] next-access delay enable
      logic       neg_en;   // [14] chip-select release delay enable
      logic       clk_en;   // [13] clock-to-data delay enable
      logic [1:0] presc;    // [12:11] prescale select
      logic       cpol;     // [10]
      logic       cpha;     // [9]
      logic       lsb;      // [8] least significant bit first
      logic [3:0] len;      // [7:4] data length code
      logic       keep;     // [3] hold chip select after segment
      logic       dir;      // [2] 1 = read in multi-lane mode
      lane_e      lane;     // [1:0]
   } cmd_t;

   typedef enum logic [2:0] {
      S_IDLE,
      S_LOAD,
      S_ISSUE,
      S_WAIT,
      S_ADV
   } seq_state_e;

endpackage

// File: rtl/spi_seq_cmd_sel.sv
module spi_seq_cmd_sel
   import spi_seq_pkg::*;
#(
   parameter int NUM_CMD = 4,
   parameter int PTR_W   = 3,
   parameter int MULT_W  = 32,
   parameter int DLY_W   = 3
) (
   input  logic [NUM_CMD*CMD_W-1:0]  cmd_table,
   input  logic [NUM_CMD*MULT_W-1:0] mult_table,
   input  logic [PTR_W-1:0]          ptr,
   input  logic [DLY_W-1:0]          lead_set,
   input  logic [DLY_W-1:0]          lag_set,
   input  logic [DLY_W-1:0]          gap_set,
   output cmd_t                      cur_cmd,
   output logic [MULT_W-1:0]         cur_mult,
   output logic                      multi_rd,
   output logic                      multi_wr,
   output logic [DLY_W-1:0]          lead_dly,
   output logic [DLY_W-1:0]          lag_dly,
   output logic [DLY_W-1:0]          gap_dly
);

   localparam int N_DLY = 3;

   cmd_t              cmd_arr  [NUM_CMD];
   logic [MULT_W-1:0] mult_arr [NUM_CMD];

   for (genvar g = 0; g < NUM_CMD; g++) begin : g_unpack
      assign cmd_arr[g]  = cmd_t'(cmd_table[g*CMD_W +: CMD_W]);
      assign mult_arr[g] = mult_table[g*MULT_W +: MULT_W];
   end

   always_comb begin
      cur_cmd  = '0;
      cur_mult = '0;
      for (int i = 0; i < NUM_CMD; i++) begin
         if (ptr == PTR_W'(i)) begin
            cur_cmd  = cmd_arr[i];
            cur_mult = mult_arr[i];
         end
      end
   end

   assign multi_rd = (cur_cmd.lane != LANE_X1) &&  cur_cmd.dir;
   assign multi_wr = (cur_cmd.lane != LANE_X1) && !cur_cmd.dir;

   logic [DLY_W-1:0] set_arr [N_DLY];
   logic [DLY_W-1:0] eff_arr [N_DLY];
   logic [N_DLY-1:0] en_vec;

   assign set_arr[0] = lead_set;
   assign set_arr[1] = lag_set;
   assign set_arr[2] = gap_set;
   assign en_vec     = {cur_cmd.nxt_en, cur_cmd.neg_en, cur_cmd.clk_en};

   for (genvar g = 0; g < N_DLY; g++) begin : g_dly
      assign eff_arr[g] = en_vec[g] ? set_arr[g] : '0;
   end

   assign lead_dly = eff_arr[0];
   assign lag_dly  = eff_arr[1];
   assign gap_dly  = eff_arr[2];

endmodule

// File: rtl/spi_seq_frame_ctr.sv
module spi_seq_frame_ctr #(
   parameter int MULT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [MULT_W-1:0] load_val,
   input  logic              dec,
   output logic              last
);

   logic [MULT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec) begin
         cnt_q <= cnt_q - MULT_W'(1);
      end
   end

   assign last = (cnt_q == MULT_W'(1));

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
   import spi_seq_pkg::*;
#(
   parameter int NUM_CMD = 4,
   parameter int PTR_W   = 3,
   parameter int MULT_W  = 32,
   parameter int DLY_W   = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [NUM_CMD*16-1:0]     cmd_table,
   input  logic [NUM_CMD*MULT_W-1:0] mult_table,
   input  logic [PTR_W-1:0]          seq_last,
   input  logic [DLY_W-1:0]          lead_set,
   input  logic [DLY_W-1:0]          lag_set,
   input  logic [DLY_W-1:0]          gap_set,
   input  logic                      frame_done,
   output logic [PTR_W-1:0]          cmd_ptr,
   output logic                      busy,
   output logic                      done,
   output logic                      frame_start,
   output logic                      cs_active,
   output logic [15:0]               act_cmd,
   output logic [1:0]                lane_mode,
   output logic                      multi_rd,
   output logic                      multi_wr,
   output logic [DLY_W-1:0]          lead_dly,
   output logic [DLY_W-1:0]          lag_dly,
   output logic [DLY_W-1:0]          gap_dly
);

   localparam logic [PTR_W-1:0] MAX_IDX = PTR_W'(NUM_CMD - 1);

   if (NUM_CMD < 1 || NUM_CMD > (1 << PTR_W)) begin : g_bad_num_cmd
      $error("NUM_CMD must lie between 1 and 2**PTR_W");
   end
   if (MULT_W < 1 || DLY_W < 1) begin : g_bad_width
      $error("MULT_W and DLY_W must be positive");
   end
   if (CMD_W != 16) begin : g_bad_cmd_w
      $error("command word must be 16 bits");
   end

   seq_state_e        state_q;
   logic [PTR_W-1:0]  ptr_q;
   logic              cs_q;
   logic              done_q;
   logic [PTR_W-1:0]  last_idx;
   cmd_t              cur_cmd;
   logic [MULT_W-1:0] cur_mult;
   logic              ctr_last;

   assign last_idx = (seq_last > MAX_IDX) ? MAX_IDX : seq_last;

   spi_seq_cmd_sel #(
      .NUM_CMD (NUM_CMD),
      .PTR_W   (PTR_W),
      .MULT_W  (MULT_W),
      .DLY_W   (DLY_W)
   ) u_sel (
      .cmd_table  (cmd_table),
      .mult_table (mult_table),
      .ptr        (ptr_q),
      .lead_set   (lead_set),
      .lag_set    (lag_set),
      .gap_set    (gap_set),
      .cur_cmd    (cur_cmd),
      .cur_mult   (cur_mult),
      .multi_rd   (multi_rd),
      .multi_wr   (multi_wr),
      .lead_dly   (lead_dly),
      .lag_dly    (lag_dly),
      .gap_dly    (gap_dly)
   );

   spi_seq_frame_ctr #(
      .MULT_W (MULT_W)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (state_q == S_LOAD),
      .load_val (cur_mult),
      .dec      ((state_q == S_WAIT) && frame_done),
      .last     (ctr_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         ptr_q   <= '0;
         cs_q    <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (start) begin
                  state_q <= S_LOAD;
                  ptr_q   <= '0;
               end
            end
            S_LOAD: begin
               if (cur_mult == '0) begin
                  state_q <= S_ADV;
               end else begin
                  state_q <= S_ISSUE;
                  cs_q    <= 1'b1;
               end
            end
            S_ISSUE: state_q <= S_WAIT;
            S_WAIT: begin
               if (frame_done) begin
                  state_q <= ctr_last ? S_ADV : S_ISSUE;
               end
            end
            S_ADV: begin
               if (ptr_q == last_idx) begin
                  state_q <= S_IDLE;
                  ptr_q   <= '0;
                  cs_q    <= 1'b0;
                  done_q  <= 1'b1;
               end else begin
                  state_q <= S_LOAD;
                  ptr_q   <= ptr_q + PTR_W'(1);
                  if (!cur_cmd.keep) begin
                     cs_q <= 1'b0;
                  end
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign cmd_ptr     = ptr_q;
   assign busy        = (state_q != S_IDLE);
   assign done        = done_q;
   assign frame_start = (state_q == S_ISSUE);
   assign cs_active   = cs_q;
   assign act_cmd     = cur_cmd;
   assign lane_mode   = cur_cmd.lane;

endmodule

// File: rtl/spi_cmd_seq_chk.sv
module spi_cmd_seq_chk #(
   parameter int NUM_CMD = 4,
   parameter int PTR_W   = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [PTR_W-1:0] cmd_ptr,
   input logic             busy,
   input logic             done,
   input logic             frame_start,
   input logic             cs_active,
   input logic             multi_rd,
   input logic             multi_wr
);

   // R1: nothing moves while idle
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!frame_start && !cs_active && cmd_ptr == '0));

   // R2: pointer never leaves the table
   p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ptr <= PTR_W'(NUM_CMD - 1));

   // R3: one frame outstanding, so no back-to-back requests
   p_fs_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);

   // R5: a frame is only requested with chip select asserted
   p_fs_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> cs_active);

   // R6: done is a single-cycle pulse and leaves the block at home
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_home_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!cs_active && cmd_ptr == '0 && !busy));

   // R7: the entry does not change while its frame is outstanding
   p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> $stable(cmd_ptr));

   // R8: read and write indications are exclusive
   p_dir_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(multi_rd && multi_wr));

   // R10: a run ends only through done
   p_end_only_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

bind spi_cmd_seq spi_cmd_seq_chk #(
   .NUM_CMD (NUM_CMD),
   .PTR_W   (PTR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_ptr     (cmd_ptr),
   .busy        (busy),
   .done        (done),
   .frame_start (frame_start),
   .cs_active   (cs_active),
   .multi_rd    (multi_rd),
   .multi_wr    (multi_wr)
);

// File: tb/spi_cmd_seq_test.sv
module spi_cmd_seq_test;

   localparam int CLK_NS  = 10;
   localparam int NUM_CMD = 4;
   localparam int PTR_W   = 3;
   localparam int MULT_W  = 32;
   localparam int DLY_W   = 3;

   logic                      clk = 1'b0;
   logic                      rst_n = 1'b0;
   logic                      start = 1'b0;
   logic [NUM_CMD*16-1:0]     cmd_table;
   logic [NUM_CMD*MULT_W-1:0] mult_table;
   logic [PTR_W-1:0]          seq_last = '0;
   logic [DLY_W-1:0]          lead_set = '0, lag_set = '0, gap_set = '0;
   logic                      frame_done = 1'b0;
   logic [PTR_W-1:0]          cmd_ptr;
   logic                      busy, done, frame_start, cs_active;
   logic [15:0]               act_cmd;
   logic [1:0]                lane_mode;
   logic                      multi_rd, multi_wr;
   logic [DLY_W-1:0]          lead_dly, lag_dly, gap_dly;

   logic [15:0]       tb_cmd  [NUM_CMD];
   logic [MULT_W-1:0] tb_mult [NUM_CMD];

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_NS/2) clk = ~clk;

   always_comb begin
      for (int i = 0; i < NUM_CMD; i++) begin
         cmd_table[i*16 +: 16]        = tb_cmd[i];
         mult_table[i*MULT_W +: MULT_W] = tb_mult[i];
      end
   end

   spi_cmd_seq #(
      .NUM_CMD (NUM_CMD), .PTR_W (PTR_W), .MULT_W (MULT_W), .DLY_W (DLY_W)
   ) uut (
      .clk (clk), .rst_n (rst_n), .start (start),
      .cmd_table (cmd_table), .mult_table (mult_table), .seq_last (seq_last),
      .lead_set (lead_set), .lag_set (lag_set), .gap_set (gap_set),
      .frame_done (frame_done), .cmd_ptr (cmd_ptr), .busy (busy), .done (done),
      .frame_start (frame_start), .cs_active (cs_active), .act_cmd (act_cmd),
      .lane_mode (lane_mode), .multi_rd (multi_rd), .multi_wr (multi_wr),
      .lead_dly (lead_dly), .lag_dly (lag_dly), .gap_dly (gap_dly)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int eff_last(input int k);
      return (k > NUM_CMD - 1) ? NUM_CMD - 1 : k;
   endfunction

   function automatic int next_nz(input int from, input int last);
      for (int e = from; e <= last; e++)
         if (tb_mult[e] != 0) return e;
      return NUM_CMD;
   endfunction

   function automatic logic [DLY_W-1:0] exp_dly(input bit en, input logic [DLY_W-1:0] s);
      return en ? s : '0;
   endfunction

   function automatic bit exp_drop(input int from, input int upto);
      bit d = 0;
      for (int e = from; e <= upto; e++) d |= !tb_cmd[e][3];
      return d;
   endfunction

   task automatic run_seq(input int k, input bit inject_start, input bit stray_done);
      int  fcount [NUM_CMD];
      int  last = eff_last(k);
      int  cur_e, remaining, prev_e, guard, pend, frames;
      bit  low_flag, injected;
      logic [15:0] c;
      for (int e = 0; e < NUM_CMD; e++) fcount[e] = 0;
      prev_e = -1; guard = 0; pend = 0; frames = 0; low_flag = 0; injected = 0;
      seq_last = PTR_W'(k);
      if (stray_done) begin
         @(negedge clk) frame_done = 1'b1;
         @(negedge clk) frame_done = 1'b0;
         chk(!busy && !frame_start, "R10", "stray frame_done while idle", {busy, frame_start}, 0);
      end
      cur_e = next_nz(0, last);
      remaining = (cur_e < NUM_CMD) ? int'(tb_mult[cur_e]) : 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      forever begin
         if (frame_done) frame_done = 1'b0;
         if (start) start = 1'b0;
         if (!cs_active) low_flag = 1;
         if (pend > 0) begin
            pend--;
            if (pend == 0) frame_done = 1'b1;
         end
         if (frame_start) begin
            frames++;
            chk(cs_active, "R5", "cs with frame_start", cs_active, 1);
            chk(int'(cmd_ptr) == cur_e, "R2", "entry order", cmd_ptr, cur_e);
            if (cur_e < NUM_CMD) begin
               c = tb_cmd[cur_e];
               chk(act_cmd == c, "R7", "active command", act_cmd, c);
               chk(lane_mode == c[1:0], "R7", "lane mode", lane_mode, c[1:0]);
               chk(multi_rd == (c[1:0] != 2'b00 && c[2]) && multi_wr == (c[1:0] != 2'b00 && !c[2]),
                   "R8", "direction", {multi_rd, multi_wr},
                   {(c[1:0] != 2'b00 && c[2]), (c[1:0] != 2'b00 && !c[2])});
               chk({lead_dly, lag_dly, gap_dly} ==
                   {exp_dly(c[13], lead_set), exp_dly(c[14], lag_set), exp_dly(c[15], gap_set)},
                   "R9", "delays", {lead_dly, lag_dly, gap_dly},
                   {exp_dly(c[13], lead_set), exp_dly(c[14], lag_set), exp_dly(c[15], gap_set)});
               if (prev_e >= 0 && prev_e != cur_e)
                  chk(low_flag == exp_drop(prev_e, cur_e - 1), "R5", "cs between segments",
                      low_flag, exp_drop(prev_e, cur_e - 1));
               else if (prev_e == cur_e)
                  chk(!low_flag, "R5", "cs within segment", low_flag, 0);
            end
            if (int'(cmd_ptr) < NUM_CMD) fcount[cmd_ptr]++;
            prev_e = cur_e; low_flag = 0;
            remaining--;
            if (remaining <= 0) begin
               cur_e = next_nz(cur_e + 1, last);
               remaining = (cur_e < NUM_CMD) ? int'(tb_mult[cur_e]) : 0;
            end
            pend = 1 + $urandom_range(0, 2);
         end
         if (inject_start && !injected && busy && frames == 1 && !done) begin
            start = 1'b1; injected = 1;
         end
         if (done) break;
         guard++;
         if (guard > 4000) begin
            chk(0, "R3", "sequence never finished", guard, 0);
            break;
         end
         @(negedge clk);
      end
      chk(!cs_active && cmd_ptr == 0, "R6", "home at done", {cs_active, cmd_ptr}, 0);
      for (int e = 0; e < NUM_CMD; e++) begin
         int exp_n = (e <= last) ? int'(tb_mult[e]) : 0;
         chk(fcount[e] == exp_n, (exp_n == 0) ? "R4" : "R3", "frames per entry", fcount[e], exp_n);
      end
      if (frame_done) frame_done = 1'b0;
      if (start) start = 1'b0;
      @(negedge clk);
      chk(!done, "R6", "done one cycle", done, 0);
      @(negedge clk);
      chk(!busy, "R10", "no restart from stray start", busy, 0);
   endtask

   task automatic rand_table(input int max_mult);
      for (int e = 0; e < NUM_CMD; e++) begin
         tb_cmd[e] = 16'($urandom);
         tb_cmd[e][1:0] = 2'($urandom_range(0, 2));
         tb_mult[e] = MULT_W'($urandom_range(0, max_mult));
      end
      lead_set = DLY_W'($urandom); lag_set = DLY_W'($urandom); gap_set = DLY_W'($urandom);
   endtask

   initial begin
      #(CLK_NS * 150000);
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog: got hang expected finished run");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      for (int e = 0; e < NUM_CMD; e++) begin tb_cmd[e] = '0; tb_mult[e] = '0; end
      repeat (3) @(negedge clk);
      chk(!busy && !done && !frame_start && !cs_active && cmd_ptr == 0, "R1", "reset state",
          {busy, done, frame_start, cs_active, cmd_ptr}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !cs_active && cmd_ptr == 0, "R1", "after reset", {busy, cs_active, cmd_ptr}, 0);

      // directed: keep mix, all entries active
      tb_cmd[0] = 16'h2019; tb_cmd[1] = 16'h4076; tb_cmd[2] = 16'h8032; tb_cmd[3] = 16'hE1F8;
      tb_mult[0] = 2; tb_mult[1] = 1; tb_mult[2] = 3; tb_mult[3] = 1;
      lead_set = 3'd5; lag_set = 3'd2; gap_set = 3'd7;
      run_seq(3, 0, 0);
      // zero in the middle with a keep-clear skipped entry
      tb_cmd[0][3] = 1'b1; tb_cmd[1][3] = 1'b0; tb_mult[1] = 0;
      run_seq(3, 0, 0);
      // zero first and last, length beyond the table
      tb_mult[0] = 0; tb_mult[1] = 4; tb_mult[3] = 0;
      run_seq(7, 0, 0);
      // single entry
      tb_mult[0] = 5;
      run_seq(0, 0, 0);
      // every count zero
      for (int e = 0; e < NUM_CMD; e++) tb_mult[e] = 0;
      run_seq(3, 0, 0);
      // stray start and frame_done
      tb_mult[0] = 2; tb_mult[1] = 2; tb_mult[2] = 1; tb_mult[3] = 2;
      run_seq(3, 1, 1);

      for (int r = 0; r < 40; r++) begin
         rand_table(3);
         run_seq($urandom_range(0, 7), r % 5 == 0, r % 7 == 0);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule